// File: doc/BRIEF.md
# Nonvolatile Store Control Sequencer

This block decides when a small volatile memory image is copied into a shadow nonvolatile array (a store), and when the shadow is copied back (a recall). A store can be started in three ways. The first is a falling edge on an active-low external request line. The second is a one-cycle software strobe. The third is a power-fail comparator flag, which is gated by an enable input; tie that input high to get the default behaviour. A recall is started by its own strobe.

A dirty flag records whether any write has landed since the last store or recall. Software stores always run. Stores from the hardware line or from power-fail run only when the image is dirty. A hardware request first opens a grace window of `DELAY_CYC` cycles. Reads continue during the window. A write that was already under way when the line fell may carry on, but no new write is accepted. While a store runs the block pulls its active-low busy output low for exactly `STORE_CYC` cycles. After any store, memory access stays disabled until the request line is seen high.

The controller is a five-state machine, and each move between states is triggered by one named condition:
- **IDLE → GRACE**: the request line falls.
- **IDLE → STORE**: a software strobe, or power-fail while enabled and dirty.
- **IDLE → RECALL**: a recall strobe.
- **GRACE → STORE**: the window expires while the image is dirty.
- **GRACE → HOLD**: the window expires while the image is clean.
- **STORE → HOLD**: the copy count expires.
- **RECALL → IDLE**: the copy count expires.
- **HOLD → IDLE**: the request line is high.

Top module: `nv_store_seq`

## Requirements
- R1: A software store strobe seen in IDLE always starts a store, dirty or not. `busy_n` is then 0 for exactly `STORE_CYC` consecutive cycles, starting the cycle after the strobe.
- R2: A store started by the hardware line or by power-fail runs only if the dirty flag is 1. Otherwise `busy_n` stays 1.
- R3: After the request line falls, `busy_n` stays 1 and `acc_off` stays 0 for `DELAY_CYC` cycles, and `rd_data` keeps returning the stored word. The store, when it runs, begins in the cycle after that window.
- R4: A write with `wr_en` held high in the cycle the line falls may keep writing for as long as `wr_en` stays high within the window. Any write begun later in the window is dropped, with `wr_block` equal to 1.
- R5: After a store or a clean hardware request, `acc_off` stays 1 while `hw_req_n` is 0. It falls one cycle after `hw_req_n` is seen at 1.
- R6: With `pf_enable` at 0, `pwr_fail` starts no store.
- R7: `dirty` becomes 1 one cycle after an accepted write. It becomes 0 when a store starts and when a recall ends.
- R8: A recall holds `acc_off` at 1 for `RECALL_CYC` cycles and then makes every volatile word equal to the nonvolatile word at the same address.
- R9: Store and recall requests that arrive while a store or recall is running are ignored. A store request and a recall request in the same cycle run the store only.
- R10: The stored image includes a write accepted in the same cycle as the store trigger, and that store leaves `dirty` at 0.
- R11: `rd_data` is 0 whenever `acc_off` is 1, and `wr_block` is 1 whenever `acc_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both arrays and the dirty flag |
| hw_req_n | input | 1 | External active-low store request line |
| sw_store | input | 1 | Software store strobe |
| pwr_fail | input | 1 | Supply-below-threshold flag |
| pf_enable | input | 1 | Enables the power-fail trigger (tie high for default) |
| recall_req | input | 1 | Recall strobe |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write word address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | WIDTH | Volatile word, or 0 while access is off |
| busy_n | output | 1 | Active-low busy; the open-drain pull-down enable, low during a store |
| wr_block | output | 1 | New writes are being rejected |
| acc_off | output | 1 | Memory access is disabled |
| dirty | output | 1 | A write has landed since the last store or recall |

## Verification
Two functions can coincide in one cycle: a write can be accepted in the same cycle that a store trigger starts the copy, and a store request can arrive in the same cycle as a recall request. The bench raises a write together with the software strobe. It then overwrites that word, recalls, and expects the word from the same-cycle write to come back with `dirty` low. For the second case it pulses both strobes at once and expects a single busy pulse of store length followed by no recall window. It also raises both strobes in the middle of a running store and expects neither to act.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRACE,
        ST_STORE,
        ST_RECALL,
        ST_HOLD
    } nvs_state_e;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int DELAY_CYC  = 4,
    parameter int STORE_CYC  = 6,
    parameter int RECALL_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req_n,
    input  logic sw_store,
    input  logic pwr_fail,
    input  logic pf_enable,
    input  logic recall_req,
    input  logic wr_en,
    output logic wr_commit,
    output logic store_copy,
    output logic recall_copy,
    output logic busy_n,
    output logic acc_off,
    output logic wr_block,
    output logic dirty
);
    localparam int MAX_AB = (DELAY_CYC > STORE_CYC) ? DELAY_CYC : STORE_CYC;
    localparam int MAXC   = (MAX_AB > RECALL_CYC) ? MAX_AB : RECALL_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    nvs_state_e       state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             hw_q;
    logic             carry;
    logic             hw_fall;
    logic             cnt_zero;
    logic             store_start;
    logic             write_open;

    assign hw_fall     = hw_q & ~hw_req_n;
    assign cnt_zero    = (cnt == '0);
    assign store_start = (state_d == ST_STORE) && (state != ST_STORE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (hw_fall) begin
                    state_d = ST_GRACE;
                    cnt_d   = CNT_W'(DELAY_CYC - 1);
                end else if (sw_store || (pwr_fail && pf_enable && dirty)) begin
                    state_d = ST_STORE;
                    cnt_d   = CNT_W'(STORE_CYC - 1);
                end else if (recall_req) begin
                    state_d = ST_RECALL;
                    cnt_d   = CNT_W'(RECALL_CYC - 1);
                end
            end
            ST_GRACE: begin
                if (cnt_zero) begin
                    if (dirty || wr_commit) begin
                        state_d = ST_STORE;
                        cnt_d   = CNT_W'(STORE_CYC - 1);
                    end else begin
                        state_d = ST_HOLD;
                    end
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            ST_STORE: begin
                if (cnt_zero) state_d = ST_HOLD;
                else          cnt_d   = cnt - 1'b1;
            end
            ST_RECALL: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt - 1'b1;
            end
            ST_HOLD: begin
                if (hw_req_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // line edge, carried write, dirty flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_q  <= 1'b1;
            carry <= 1'b0;
            dirty <= 1'b0;
        end else begin
            hw_q <= hw_req_n;
            unique case (state)
                ST_IDLE:  carry <= wr_en;
                ST_GRACE: carry <= carry & wr_en;
                default:  carry <= 1'b0;
            endcase
            if (store_start || recall_copy) dirty <= 1'b0;
            else if (wr_commit)             dirty <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        write_open  = (state == ST_IDLE) || ((state == ST_GRACE) && carry);
        wr_commit   = wr_en && write_open;
        wr_block    = !write_open;
        acc_off     = (state == ST_STORE) || (state == ST_RECALL) || (state == ST_HOLD);
        busy_n      = (state != ST_STORE);
        store_copy  = (state == ST_STORE) && cnt_zero;
        recall_copy = (state == ST_RECALL) && cnt_zero;
    end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_commit,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             store_copy,
    input  logic             recall_copy,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] vol_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [WIDTH-1:0] vword;
        logic [WIDTH-1:0] nword;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vword <= '0;
                nword <= '0;
            end else begin
                if (store_copy) nword <= vword;
                if (recall_copy)
                    vword <= nword;
                else if (wr_commit && (wr_addr == AW'(g)))
                    vword <= wr_data;
            end
        end

        assign vol_w[g] = vword;
    end

    assign rd_data = rd_en ? vol_w[rd_addr] : '0;
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
    parameter int DEPTH      = 8,
    parameter int WIDTH      = 8,
    parameter int DELAY_CYC  = 4,
    parameter int STORE_CYC  = 6,
    parameter int RECALL_CYC = 5,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req_n,
    input  logic             sw_store,
    input  logic             pwr_fail,
    input  logic             pf_enable,
    input  logic             recall_req,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy_n,
    output logic             wr_block,
    output logic             acc_off,
    output logic             dirty
);
    logic wr_commit;
    logic store_copy;
    logic recall_copy;

    nvs_ctrl #(
        .DELAY_CYC (DELAY_CYC),
        .STORE_CYC (STORE_CYC),
        .RECALL_CYC(RECALL_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_req_n   (hw_req_n),
        .sw_store   (sw_store),
        .pwr_fail   (pwr_fail),
        .pf_enable  (pf_enable),
        .recall_req (recall_req),
        .wr_en      (wr_en),
        .wr_commit  (wr_commit),
        .store_copy (store_copy),
        .recall_copy(recall_copy),
        .busy_n     (busy_n),
        .acc_off    (acc_off),
        .wr_block   (wr_block),
        .dirty      (dirty)
    );

    nvs_arrays #(
        .DEPTH(DEPTH),
        .WIDTH(WIDTH)
    ) u_arrays (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .store_copy (store_copy),
        .recall_copy(recall_copy),
        .rd_en      (!acc_off),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
    parameter int STORE_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic hw_req_n,
    input logic wr_en,
    input logic busy_n,
    input logic wr_block,
    input logic acc_off,
    input logic dirty
);
    localparam int LW = $clog2(STORE_CYC + 2) + 1;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt <= '0;
        else if (!busy_n) low_cnt <= low_cnt + 1'b1;
        else              low_cnt <= '0;
    end

    assert_busy_blocks_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> acc_off);

    assert_pulse_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == LW'(STORE_CYC)));

    assert_store_cleans_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> !dirty);

    assert_dirty_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> ($past(wr_en) && !$past(wr_block)));

    assert_off_blocks_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_off |-> wr_block);

    assert_hold_while_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_n) && !hw_req_n) |-> acc_off);
endmodule

bind nv_store_seq nvs_chk #(.STORE_CYC(STORE_CYC)) u_nvs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req_n(hw_req_n),
    .wr_en   (wr_en),
    .busy_n  (busy_n),
    .wr_block(wr_block),
    .acc_off (acc_off),
    .dirty   (dirty)
);

// File: tb/test_nv_store_seq.sv
module test_nv_store_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WIDTH = 8;
    localparam int DLY   = 4;
    localparam int ST    = 6;
    localparam int RC    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req_n = 1'b1, sw_store = 1'b0, pwr_fail = 1'b0, pf_enable = 1'b1;
    logic recall_req = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [WIDTH-1:0] wr_data = '0, rd_data;
    logic busy_n, wr_block, acc_off, dirty;

    int total = 0, bad = 0;
    logic [WIDTH-1:0] vol_m [DEPTH];
    logic [WIDTH-1:0] nv_m  [DEPTH];
    logic dirty_m = 1'b0;

    nv_store_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DELAY_CYC(DLY),
                   .STORE_CYC(ST), .RECALL_CYC(RC)) i_nv_store_seq (
        .clk(clk), .rst_n(rst_n), .hw_req_n(hw_req_n), .sw_store(sw_store),
        .pwr_fail(pwr_fail), .pf_enable(pf_enable), .recall_req(recall_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy_n(busy_n), .wr_block(wr_block),
        .acc_off(acc_off), .dirty(dirty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic bit will_store(input int op, input bit d);
        return (op == 1) || (op == 3 && d);
    endfunction

    function automatic int exp_off_len(input int op, input bit d);
        if (will_store(op, d)) return ST + 1;
        if (op == 2)           return RC;
        return 0;
    endfunction

    task automatic write(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = WIDTH'(d);
        @(negedge clk);
        wr_en = 1'b0;
        vol_m[a] = WIDTH'(d); dirty_m = 1'b1;
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 3'(a); #1;
            check(int'(rd_data), int'(vol_m[a]), req);
        end
        check(int'(dirty), int'(dirty_m), "R7 dirty");
    endtask

    // op: 0 none, 1 software store, 2 recall, 3 power-fail, 4 store+recall
    task automatic trig(input int op, output int blow, output int alen);
        @(negedge clk);
        sw_store   = (op == 1 || op == 4);
        recall_req = (op == 2 || op == 4);
        pwr_fail   = (op == 3);
        @(negedge clk);
        sw_store = 1'b0; recall_req = 1'b0; pwr_fail = 1'b0;
        blow = 0; alen = 0;
        for (int i = 0; i < 30; i++) begin
            if (!busy_n) blow++;
            if (acc_off) alen++;
            @(negedge clk);
        end
    endtask

    task automatic hw_request(output int blow, output int first_low);
        @(negedge clk);
        hw_req_n = 1'b0; rd_addr = 3'd0;
        blow = 0; first_low = 0;
        for (int i = 1; i <= DLY + ST + 3; i++) begin
            @(negedge clk);
            if (i == 1) begin
                #1;
                check(int'(busy_n), 1, "R3 grace busy");
                check(int'(acc_off), 0, "R3 grace access");
                check(int'(wr_block), 1, "R4 grace block");
                check(int'(rd_data), int'(vol_m[0]), "R3 grace read");
            end
            if (!busy_n) begin
                blow++;
                if (first_low == 0) first_low = i;
            end
        end
        check(int'(acc_off), 1, "R5 held off while line low");
        check(int'(busy_n), 1, "R5 busy released");
        hw_req_n = 1'b1;
        @(negedge clk);
        check(int'(acc_off), 0, "R5 access back after release");
    endtask

    task automatic do_store_model();
        for (int a = 0; a < DEPTH; a++) nv_m[a] = vol_m[a];
        dirty_m = 1'b0;
    endtask

    task automatic do_recall_model();
        for (int a = 0; a < DEPTH; a++) vol_m[a] = nv_m[a];
        dirty_m = 1'b0;
    endtask

    initial begin
        int blow, alen, fl;
        int seed;
        for (int a = 0; a < DEPTH; a++) begin vol_m[a] = '0; nv_m[a] = '0; end
        seed = 32'd4242;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(int'(busy_n), 1, "R1 reset busy");
        check(int'(acc_off), 1'b0, "R11 reset access");
        check(int'(dirty), 0, "R7 reset dirty");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8 reset image");

        // R1: clean software store still runs
        trig(1, blow, alen);
        check(blow, ST, "R1 clean sw store pulse");
        check(alen, ST + 1, "R1 access window");
        do_store_model();

        // R2: power-fail and hardware ignored when clean
        trig(3, blow, alen);
        check(blow, 0, "R2 clean power-fail");
        hw_request(blow, fl);
        check(blow, 0, "R2 clean hw request");

        // R6 / R7
        write(1, 8'h3C);
        check(int'(dirty), 1, "R7 set by write");
        pf_enable = 1'b0;
        trig(3, blow, alen);
        check(blow, 0, "R6 power-fail disabled");
        check(int'(dirty), 1, "R6 dirty kept");
        pf_enable = 1'b1;
        trig(3, blow, alen);
        check(blow, ST, "R2 dirty power-fail");
        do_store_model();
        check(int'(dirty), 0, "R7 cleared by store");

        // R2/R3/R5: dirty hardware request
        write(0, 8'h5A);
        hw_request(blow, fl);
        check(blow, ST, "R2 dirty hw store");
        check(fl, DLY + 1, "R3 store after window");
        do_store_model();
        check_all("R2 image after hw store");

        // R4: carried write vs new write in the window
        @(negedge clk);
        hw_req_n = 1'b0; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hA1;
        @(negedge clk);
        #1 check(int'(wr_block), 0, "R4 carried write open");
        wr_data = 8'hB2;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'hC3;
        #1 check(int'(wr_block), 1, "R4 new write blocked");
        @(negedge clk);
        wr_en = 1'b0;
        repeat (ST + 3) @(negedge clk);
        hw_req_n = 1'b1;
        @(negedge clk);
        vol_m[2] = 8'hB2;
        do_store_model();
        check_all("R4 window writes");

        // R10: write in the same cycle as the store trigger
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h5E; sw_store = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sw_store = 1'b0;
        repeat (15) @(negedge clk);
        vol_m[5] = 8'h5E; do_store_model();
        check(int'(dirty), 0, "R10 dirty after same-cycle store");
        write(5, 8'h77);
        trig(2, blow, alen);
        check(alen, RC, "R8 recall window");
        check(blow, 0, "R8 recall no busy");
        do_recall_model();
        check_all("R10 recalled image");

        // R9: store and recall together -> store only
        write(1, 8'h11);
        trig(4, blow, alen);
        check(blow, ST, "R9 store wins");
        check(alen, ST + 1, "R9 no recall after store");
        do_store_model();
        write(1, 8'h22);
        trig(2, blow, alen);
        do_recall_model();
        check_all("R9 store image recalled");

        // R9/R11: requests during a running store
        write(4, 8'h44);
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0; rd_addr = 3'd4;
        blow = 0; alen = 0;
        for (int i = 0; i < 30; i++) begin
            if (!busy_n) blow++;
            if (acc_off) alen++;
            if (i == 2) begin
                #1 check(int'(rd_data), 0, "R11 read masked");
                recall_req = 1'b1; sw_store = 1'b1;
            end
            if (i == 3) begin recall_req = 1'b0; sw_store = 1'b0; end
            @(negedge clk);
        end
        check(blow, ST, "R9 ignored during store");
        check(alen, ST + 1, "R9 no late recall");
        do_store_model();
        check_all("R9 image after ignored requests");

        // random mix
        for (int it = 0; it < 30; it++) begin
            int nw, op;
            bit d;
            nw = int'($urandom % 4);
            for (int k = 0; k < nw; k++) write(int'($urandom % DEPTH), int'($urandom % 256));
            op = int'($urandom % 4);
            d = dirty_m;
            trig(op, blow, alen);
            check(blow, will_store(op, d) ? ST : 0, "R1 random busy pulse");
            check(alen, exp_off_len(op, d), "R8 random access window");
            if (will_store(op, d)) do_store_model();
            else if (op == 2) do_recall_model();
            check_all("R10 random image");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule